// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs one external memory read or write on a shared address/data bus. A core places a request (address, byte-high enable, write data and per-access timing options) and holds `req_valid`. The block latches the request and pulses the address-latch strobe while the address is on the bus. It then drives the read or write strobe for a programmed length and returns a one-cycle acknowledge, which carries the captured data for a read. One clock period of the block is one half-clock timing unit (TCL).

The timing options apply to one access only. An inverted 4-bit wait field sets the strobe length. An ALE extension adds one TCL to the address phase. A read/write delay holds back the strobe edge by one TCL. A recovery option inserts two idle TCL before the acknowledge. An optional active-low ready input can stretch the strobe in steps of two TCL. It is sampled either directly or through a two-flop synchronizer.

The controller has seven states. `ST_IDLE` goes to `ST_ALE` on a request. `ST_ALE` goes to `ST_SETUP` when its count runs out. `ST_SETUP` goes to `ST_DELAY` when the delay option is set and to `ST_STROBE` when it is not. `ST_DELAY` goes to `ST_STROBE`. `ST_STROBE` loops on itself for each ready wait state and otherwise goes to `ST_RECOVER` or `ST_DONE`. `ST_RECOVER` goes to `ST_DONE`. `ST_DONE` returns to `ST_IDLE`.

Top module: `xbus_cycle_seq`

## Requirements
- R1: After reset, and whenever idle, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_bhe_n`=1, `bus_ad_oe`=0 and `req_ack`=0.
- R2: `bus_ale` is high for 1 TCL, or for 2 TCL when `req_ale_ext`=1. While it is high, the bus is driven (`bus_ad_oe`=1) and `bus_ad_out` equals the latched address and does not change.
- R3: With ready not in use, the strobe (`bus_rd_n` or `bus_wr_n` low) lasts 2·(16−W) TCL, where W is `req_wait_inv`. W=15 gives 2 TCL and W=0 gives 32 TCL.
- R4: Between the falling edge of ALE and the strobe there is 1 TCL, or 2 TCL when `req_rw_delay`=1. No strobe is low while ALE is high.
- R5: A read (`req_write`=0) releases the bus (`bus_ad_oe`=0) from the fall of ALE until the strobe ends. It drives only `bus_rd_n`, and the value of `bus_ad_in` in the last strobe TCL appears on `rsp_rdata` when `req_ack` is high.
- R6: A write (`req_write`=1) drives `bus_ad_out`=write data with `bus_ad_oe`=1 from the fall of ALE through the end of the strobe. It drives only `bus_wr_n`, and the two strobes are never low together.
- R7: Counting from the first TCL after the strobe to the acknowledge TCL inclusive, the span is 1 TCL, or 3 TCL when `req_recovery`=1.
- R8: `bus_bhe_n` equals the inverse of `req_bhe` from the first ALE TCL through the last strobe TCL.
- R9: With `req_ready_en`=1, the ready input is first sampled in the last TCL of the programmed strobe, after all programmed waits. `bus_ready_n`=1 there adds 2 TCL and samples again, and `bus_ready_n`=0 ends the strobe. With `req_ready_en`=0 the ready input has no effect on the strobe length.
- R10: With `req_ready_async`=1 the ready input passes through two flip-flops first, so each sample sees the level from 2 TCL earlier.
- R11: `req_ack` is high for exactly one TCL per access, and the block is idle in the TCL after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per TCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Access address |
| req_bhe | input | 1 | High byte enable |
| req_wdata | input | BUS_W | Write data |
| req_wait_inv | input | 4 | Inverted wait-state count |
| req_ale_ext | input | 1 | Lengthen ALE by one TCL |
| req_rw_delay | input | 1 | Delay strobe edge by one TCL |
| req_recovery | input | 1 | Add two-TCL recovery after the strobe |
| req_ready_en | input | 1 | Allow ready to stretch the strobe |
| req_ready_async | input | 1 | Synchronize ready through two flops |
| req_ack | output | 1 | One-TCL completion pulse |
| rsp_rdata | output | BUS_W | Captured read data |
| bus_ad_out | output | BUS_W | Address/data driven value |
| bus_ad_oe | output | 1 | Bus output enable |
| bus_ad_in | input | BUS_W | Bus read value |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_ready_n | input | 1 | Ready, low ends the strobe |

## Verification
A wrong state or a wrong count shows at the pins within the same access. The ALE, gap, strobe or tail length comes out one or more TCL off. The bus may also be driven during a read strobe, which shows in the first strobe TCL. A slip in ready sampling moves the end of the strobe by exactly two TCL, in both synchronous and synchronized modes. A capture on the wrong edge gives read data that encodes the wrong strobe TCL, so the bench drives a different value in each strobe TCL and can tell exactly which one was latched.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int WAIT_W = 4;
    localparam int TMR_W  = WAIT_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_SETUP,
        ST_DELAY,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic              write;
        logic              bhe;
        logic [WAIT_W-1:0] wait_inv;
        logic              ale_ext;
        logic              rw_delay;
        logic              recovery;
        logic              ready_en;
        logic              ready_async;
    } acc_cfg_t;
endpackage

// File: rtl/xbus_ready_sync.sv
module xbus_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_n,
    input  logic async_sel,
    output logic not_ready
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= ready_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign not_ready = async_sel ? chain[STAGES-1] : ready_n;
endmodule

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic             req_bhe,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [3:0]       req_wait_inv,
    input  logic             req_ale_ext,
    input  logic             req_rw_delay,
    input  logic             req_recovery,
    input  logic             req_ready_en,
    input  logic             req_ready_async,
    output logic             req_ack,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic             bus_ale,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_bhe_n,
    input  logic             bus_ready_n
);
    seq_state_t        state, state_nx;
    acc_cfg_t          cfg;
    logic [BUS_W-1:0]  addr_q, wdata_q, rdata_q;
    logic              tmr_load, tmr_zero, not_ready;
    logic [TMR_W-1:0]  tmr_val;
    logic              accept, capture;

    xbus_ready_sync #(.STAGES(2)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_n   (bus_ready_n),
        .async_sel (cfg.ready_async),
        .not_ready (not_ready)
    );

    xbus_phase_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    // next state and timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(req_ale_ext);
                    state_nx = ST_ALE;
                end
            end
            ST_ALE: begin
                if (tmr_zero) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                if (cfg.rw_delay) begin
                    state_nx = ST_DELAY;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'({~cfg.wait_inv, 1'b1});
                    state_nx = ST_STROBE;
                end
            end
            ST_DELAY: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'({~cfg.wait_inv, 1'b1});
                state_nx = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    if (cfg.ready_en && not_ready) begin
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(1);
                    end else begin
                        capture = ~cfg.write;
                        if (cfg.recovery) begin
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(1);
                            state_nx = ST_RECOVER;
                        end else begin
                            state_nx = ST_DONE;
                        end
                    end
                end
            end
            ST_RECOVER: begin
                if (tmr_zero) state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cfg.write       <= req_write;
                cfg.bhe         <= req_bhe;
                cfg.wait_inv    <= req_wait_inv;
                cfg.ale_ext     <= req_ale_ext;
                cfg.rw_delay    <= req_rw_delay;
                cfg.recovery    <= req_recovery;
                cfg.ready_en    <= req_ready_en;
                cfg.ready_async <= req_ready_async;
                addr_q          <= req_addr;
                wdata_q         <= req_wdata;
            end
            if (capture) rdata_q <= bus_ad_in;
        end
    end

    // outputs
    always_comb begin
        bus_ale    = 1'b0;
        bus_ad_oe  = 1'b0;
        bus_ad_out = '0;
        bus_rd_n   = 1'b1;
        bus_wr_n   = 1'b1;
        bus_bhe_n  = 1'b1;
        req_ack    = 1'b0;
        unique case (state)
            ST_IDLE, ST_RECOVER: ;
            ST_ALE: begin
                bus_ale    = 1'b1;
                bus_ad_oe  = 1'b1;
                bus_ad_out = addr_q;
                bus_bhe_n  = ~cfg.bhe;
            end
            ST_SETUP, ST_DELAY: begin
                bus_ad_oe  = cfg.write;
                bus_ad_out = cfg.write ? wdata_q : '0;
                bus_bhe_n  = ~cfg.bhe;
            end
            ST_STROBE: begin
                bus_ad_oe  = cfg.write;
                bus_ad_out = cfg.write ? wdata_q : '0;
                bus_bhe_n  = ~cfg.bhe;
                bus_rd_n   = cfg.write;
                bus_wr_n   = ~cfg.write;
            end
            ST_DONE: req_ack = 1'b1;
            default: ;
        endcase
    end

    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/xbus_cycle_seq_chk.sv
module xbus_cycle_seq_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_ale,
    input logic [BUS_W-1:0] bus_ad_out,
    input logic             bus_ad_oe,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             req_ack
);
    p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> bus_ad_oe);

    p_ale_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && $past(bus_ale)) |-> $stable(bus_ad_out));

    p_ale_max_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && $past(bus_ale)) |=> !bus_ale);

    p_strobe_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |=> (!bus_rd_n || !bus_wr_n));

    p_no_strobe_in_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n));

    p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    p_read_released_before_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> !$past(bus_ad_oe));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ale    (bus_ale),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .req_ack    (req_ack)
);

// File: tb/xbus_cycle_seq_tb.sv
`timescale 1ns/1ps
module xbus_cycle_seq_tb;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_bhe = 1'b0;
    logic [BW-1:0] req_addr = '0, req_wdata = '0, bus_ad_in = '0;
    logic [3:0]    req_wait_inv = 4'd15;
    logic          req_ale_ext = 1'b0, req_rw_delay = 1'b0, req_recovery = 1'b0;
    logic          req_ready_en = 1'b0, req_ready_async = 1'b0;
    logic          bus_ready_n = 1'b1;
    logic          req_ack, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n;
    logic [BW-1:0] rsp_rdata, bus_ad_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xbus_cycle_seq #(.BUS_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bhe(req_bhe), .req_wdata(req_wdata),
        .req_wait_inv(req_wait_inv), .req_ale_ext(req_ale_ext),
        .req_rw_delay(req_rw_delay), .req_recovery(req_recovery),
        .req_ready_en(req_ready_en), .req_ready_async(req_ready_async),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n),
        .bus_ready_n(bus_ready_n)
    );

    // [31] write, [30:27] wait_inv, [26] ale_ext, [25] rw_delay, [24] recovery,
    // [23] bhe, [22:16] expected strobe TCL, [15:0] address
    localparam logic [31:0] VEC [8] = '{
        {1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b1, 7'd2,  16'h1234},
        {1'b0, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 7'd2,  16'h4321},
        {1'b1, 4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 7'd32, 16'hA0F0},
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 7'd32, 16'h0F0F},
        {1'b0, 4'd12, 1'b0, 1'b1, 1'b0, 1'b0, 7'd8,  16'hBEEF},
        {1'b1, 4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 7'd18, 16'hCAFE},
        {1'b0, 4'd9,  1'b0, 1'b0, 1'b1, 1'b1, 7'd14, 16'h55AA},
        {1'b1, 4'd14, 1'b0, 1'b1, 1'b1, 1'b1, 7'd4,  16'hFFFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        chk(!bus_ale && bus_rd_n && bus_wr_n && bus_bhe_n && !bus_ad_oe && !req_ack,
            req, {bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ad_oe, req_ack}, 6'b011100);
    endtask

    task automatic run_access(input logic w, input logic [3:0] wf, input logic ext,
                              input logic dly, input logic rec, input logic bhe,
                              input logic [15:0] addr, input logic ren, input logic rasync,
                              input int xr, input int exp_str, input string tag);
        int ale_c = 0, gap_c = 0, str_c = 0, tail_c = 0;
        int bad_addr = 0, bad_bus = 0, bad_kind = 0, bad_bhe = 0;
        logic [15:0] wd = addr ^ 16'h3C3C;
        logic [15:0] got;
        bit acked = 1'b0;
        @(negedge clk);
        req_write = w; req_wait_inv = wf; req_ale_ext = ext; req_rw_delay = dly;
        req_recovery = rec; req_bhe = bhe; req_addr = addr; req_wdata = wd;
        req_ready_en = ren; req_ready_async = rasync; req_valid = 1'b1;
        bus_ready_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got = '0;
        for (int cyc = 0; cyc < 300; cyc++) begin
            if (bus_ale) begin
                ale_c++;
                if (!bus_ad_oe || bus_ad_out != addr) bad_addr++;
                if (bus_bhe_n != !bhe) bad_bhe++;
            end else if (!bus_rd_n || !bus_wr_n) begin
                str_c++;
                bus_ad_in   = addr ^ 16'(str_c);
                bus_ready_n = (str_c < xr);
                if (w ? bus_rd_n == 1'b0 : bus_wr_n == 1'b0) bad_kind++;
                if (w ? (!bus_ad_oe || bus_ad_out != wd) : bus_ad_oe) bad_bus++;
                if (bus_bhe_n != !bhe) bad_bhe++;
            end else if (str_c == 0) begin
                gap_c++;
                if (w ? (!bus_ad_oe || bus_ad_out != wd) : bus_ad_oe) bad_bus++;
                if (bus_bhe_n != !bhe) bad_bhe++;
            end else begin
                tail_c++;
                bus_ready_n = 1'b1;
            end
            if (req_ack) begin
                got = rsp_rdata;
                acked = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(ale_c == 1 + int'(ext), {"R2 ale length ", tag}, ale_c, 1 + int'(ext));
        chk(bad_addr == 0, {"R2 address on bus ", tag}, bad_addr, 0);
        chk(gap_c == 1 + int'(dly), {"R4 gap ", tag}, gap_c, 1 + int'(dly));
        chk(str_c == exp_str, {"R3/R9/R10 strobe length ", tag}, str_c, exp_str);
        chk(tail_c == 1 + 2 * int'(rec), {"R7 tail ", tag}, tail_c, 1 + 2 * int'(rec));
        chk(bad_bhe == 0, {"R8 bhe ", tag}, bad_bhe, 0);
        if (w) begin
            chk(bad_bus == 0, {"R6 write bus ", tag}, bad_bus, 0);
            chk(bad_kind == 0, {"R6 strobe kind ", tag}, bad_kind, 0);
        end else begin
            chk(bad_bus == 0, {"R5 bus released ", tag}, bad_bus, 0);
            chk(bad_kind == 0, {"R5 strobe kind ", tag}, bad_kind, 0);
            chk(got == (addr ^ 16'(exp_str)), {"R5 read data ", tag},
                int'(got), int'(addr ^ 16'(exp_str)));
        end
        chk(acked, {"R11 ack seen ", tag}, int'(acked), 1);
        @(negedge clk);
        idle_check({"R11 idle after ack ", tag});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_check("R1 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 outputs after reset");

        for (int i = 0; i < 8; i++) begin
            run_access(VEC[i][31], VEC[i][30:27], VEC[i][26], VEC[i][25], VEC[i][24],
                       VEC[i][23], VEC[i][15:0], 1'b0, 1'b0, 0,
                       int'(VEC[i][22:16]), $sformatf("vec%0d", i));
        end

        // R9: ready high at the first sample adds wait states (sync)
        run_access(1'b0, 4'd15, 1'b0, 1'b0, 0, 1'b1, 16'h1111, 1'b1, 1'b0, 5, 6, "r9_sync_stretch");
        // R9: ready low at once, programmed waits still all run
        run_access(1'b1, 4'd14, 1'b0, 1'b0, 0, 1'b0, 16'h2222, 1'b1, 1'b0, 0, 4, "r9_ready_low");
        run_access(1'b0, 4'd13, 1'b0, 1'b0, 0, 1'b1, 16'h3333, 1'b1, 1'b0, 1, 6, "r9_after_waits");
        // R9: ready held high but not enabled has no effect
        run_access(1'b0, 4'd15, 1'b0, 1'b0, 0, 1'b0, 16'h4444, 1'b0, 1'b0, 1000, 2, "r9_ignored");
        // R10: synchronized ready lags by two TCL
        run_access(1'b0, 4'd15, 1'b0, 1'b0, 1, 1'b1, 16'h5555, 1'b1, 1'b1, 5, 8, "r10_async");
        run_access(1'b1, 4'd14, 1'b1, 1'b1, 0, 1'b0, 16'h6666, 1'b1, 1'b1, 3, 6, "r10_async_wr");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule